// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status byte that a NOR flash returns while one of its internal program or sector-erase algorithms is running. A sequencer pulses `opStart` with the operation type, the target address and data, and an 8-bit mask of the sectors to erase. A programmable countdown (`busyCycles`) stands in for the real algorithm time. While the countdown runs, the block holds `readyOut` low. Each read strobe then returns a status byte instead of array contents. That byte carries a data-polling bit in position 7, a global toggle bit in position 6 and a sector-aware toggle bit in position 2.

When no operation is active, reads return bytes from a small behavioural array. When an operation ends, the block commits it to that array: a program stores its byte, and an erase sets every byte of the selected sectors to all ones. Firmware-style polling can therefore be exercised end to end.

Top module: `fsStatusGen`

## Requirements
- R1: After reset `readyOut` is 1, `rdData` is 0x00 and every array byte holds 0xFF.
- R2: A read strobe while idle returns the array byte at `rdAddr` on `rdData` one clock later, and `rdData` holds its value until the next read strobe.
- R3: An accepted `opStart` drives `readyOut` low for exactly `busyCycles` clocks, starting the cycle after the strobe. A `busyCycles` of 0 behaves as 1.
- R4: During a program, bit 7 of every status read is the inverse of bit 7 of the byte being programmed. After completion, a read of the program address returns the programmed byte.
- R5: During an erase, bit 7 of every status read is 0. After completion, every byte in a selected sector reads 0xFF and bytes in other sectors keep their values.
- R6: Bit 6 comes from a toggle flop that is cleared when an operation is accepted. Every busy read inverts it at any address, and the read returns the inverted value, so the first busy read gives 1.
- R7: Bit 2 comes from a second toggle flop, cleared at operation start. It inverts only on erase-time reads whose address lies in a selected sector. Other reads return it unchanged, so it is 0 throughout a program.
- R8: In a status byte, bits 5, 4, 3, 1 and 0 are 0.
- R9: An `opStart` that arrives while busy is ignored. It neither changes the running operation nor its committed result.
- R10: The sector number is the top 3 address bits (`rdAddr[7:5]` with the default 8-bit address). Mask bit i selects sector i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opStart | input | 1 | One-cycle strobe that begins an operation |
| opErase | input | 1 | Operation type at start: 1 erase, 0 program |
| progAddr | input | ADDR_W | Program target address |
| progData | input | 8 | Byte to program |
| eraseMask | input | 8 | One bit per sector to erase |
| busyCycles | input | CNT_W | Length of the busy phase in clocks |
| rdStrobe | input | 1 | One-cycle read strobe |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Status byte or array byte from the last read |
| readyOut | output | 1 | 1 when ready, 0 while an operation runs |

## Verification
The hardest case to reach is an erase in which the two toggle bits move apart. Bit 6 must flip on every read, while bit 2 must flip only on reads inside selected sectors. The stimulus selects two non-adjacent sectors and uses a busy window long enough for several reads. It then interleaves reads inside and outside those sectors, so each combination of the two bits appears. A second start strobe issued in the middle of a program, naming an erase of every sector, shows that the in-flight operation survives it.

// File: rtl/fsStatPkg.sv
package fsStatPkg;
  localparam int STAT_W = 8;
  localparam int SECT_W = 3;
  localparam int NUM_SECT = 1 << SECT_W;

  typedef struct packed {
    logic load;      // accept a new operation
    logic commit;    // last busy cycle: write result to array
    logic busyRead;  // read while an operation runs
    logic idleRead;  // read of array contents
  } fsCtl_t;
endpackage

// File: rtl/fsStatusCtl.sv
module fsStatusCtl
  import fsStatPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opStart,
  input  logic [CNT_W-1:0] busyCycles,
  input  logic             rdStrobe,
  output fsCtl_t           ctl,
  output logic             busy
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cntQ <= '0;
    end else if (!busy && opStart) begin
      busy <= 1'b1;
      cntQ <= (busyCycles == '0) ? ONE : busyCycles;
    end else if (busy) begin
      if (cntQ <= ONE) begin
        busy <= 1'b0;
        cntQ <= '0;
      end else begin
        cntQ <= cntQ - ONE;
      end
    end
  end

  always_comb begin
    ctl.load     = opStart && !busy;
    ctl.commit   = busy && (cntQ <= ONE);
    ctl.busyRead = rdStrobe && busy;
    ctl.idleRead = rdStrobe && !busy;
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    busy && (cntQ > ONE) |=> busy);  // R3
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(opStart));  // R3
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    busy && (cntQ <= ONE) |=> !busy);  // R3
endmodule

// File: rtl/fsStatusDp.sv
module fsStatusDp
  import fsStatPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fsCtl_t            ctl,
  input  logic              opErase,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [STAT_W-1:0] progData,
  input  logic [NUM_SECT-1:0] eraseMask,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [STAT_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WORDS_PER_SECT = DEPTH / NUM_SECT;

  logic                opEraseQ;
  logic [ADDR_W-1:0]   progAddrQ;
  logic [STAT_W-1:0]   progDataQ;
  logic [NUM_SECT-1:0] maskQ;
  logic                q6Q;
  logic                q2Q;
  logic [STAT_W-1:0]   mem [DEPTH];

  logic [SECT_W-1:0]   rdSect;
  logic                rdInErase;
  logic                q2Flip;
  logic [STAT_W-1:0]   statusByte;

  // operation latches and toggle flops
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opEraseQ  <= 1'b0;
      progAddrQ <= '0;
      progDataQ <= '0;
      maskQ     <= '0;
      q6Q       <= 1'b0;
      q2Q       <= 1'b0;
    end else if (ctl.load) begin
      opEraseQ  <= opErase;
      progAddrQ <= progAddr;
      progDataQ <= progData;
      maskQ     <= eraseMask;
      q6Q       <= 1'b0;
      q2Q       <= 1'b0;
    end else if (ctl.busyRead) begin
      q6Q <= ~q6Q;
      if (q2Flip) q2Q <= ~q2Q;
    end
  end

  // behavioural array, one word per generate instance
  for (genvar w = 0; w < DEPTH; w++) begin : gWord
    localparam int SECT_IDX = w / WORDS_PER_SECT;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mem[w] <= '1;
      end else if (ctl.commit) begin
        if (!opEraseQ && (progAddrQ == ADDR_W'(w))) mem[w] <= progDataQ;
        else if (opEraseQ && maskQ[SECT_IDX]) mem[w] <= '1;
      end
    end
  end

  always_comb begin
    rdSect    = rdAddr[ADDR_W-1 -: SECT_W];
    rdInErase = maskQ[rdSect];
    q2Flip    = opEraseQ && rdInErase;
    statusByte      = '0;
    statusByte[7]   = opEraseQ ? 1'b0 : ~progDataQ[7];
    statusByte[6]   = ~q6Q;
    statusByte[2]   = q2Flip ? ~q2Q : q2Q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (ctl.busyRead) rdData <= statusByte;
    else if (ctl.idleRead) rdData <= mem[rdAddr];
  end

  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busyRead && opEraseQ |=> !rdData[7]);  // R5
  AST_Q6_ALTERNATES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busyRead && !ctl.load |=> rdData[6] == q6Q);  // R6
  AST_STATUS_ZEROS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busyRead |=> (rdData[5:3] == 3'b000) && (rdData[1:0] == 2'b00));  // R8
  AST_Q2_QUIET_PROGRAM: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busyRead && !opEraseQ |=> !rdData[2]);  // R7
  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(progDataQ) && $stable(opEraseQ) && $stable(maskQ));  // R9
  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.busyRead && !ctl.idleRead |=> $stable(rdData));  // R2
endmodule

// File: rtl/fsStatusGen.sv
module fsStatusGen
  import fsStatPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opStart,
  input  logic                opErase,
  input  logic [ADDR_W-1:0]   progAddr,
  input  logic [STAT_W-1:0]   progData,
  input  logic [NUM_SECT-1:0] eraseMask,
  input  logic [CNT_W-1:0]    busyCycles,
  input  logic                rdStrobe,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [STAT_W-1:0]   rdData,
  output logic                readyOut
);
  fsCtl_t ctl;
  logic   busy;

  fsStatusCtl #(.CNT_W(CNT_W)) uCtl (
    .clk(clk), .rstN(rstN), .opStart(opStart), .busyCycles(busyCycles),
    .rdStrobe(rdStrobe), .ctl(ctl), .busy(busy)
  );

  fsStatusDp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opErase(opErase),
    .progAddr(progAddr), .progData(progData), .eraseMask(eraseMask),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  assign readyOut = ~busy;
endmodule

// File: tb/fsStatusGen_test.sv
module fsStatusGen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opStart = 1'b0;
  logic       opErase = 1'b0;
  logic [7:0] progAddr = '0;
  logic [7:0] progData = '0;
  logic [7:0] eraseMask = '0;
  logic [15:0] busyCycles = '0;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       readyOut;

  int checks = 0;
  int fails = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdSeen = 1'b0;
  bit         done = 1'b0;

  fsStatusGen uut (
    .clk(clk), .rstN(rstN), .opStart(opStart), .opErase(opErase),
    .progAddr(progAddr), .progData(progData), .eraseMask(eraseMask),
    .busyCycles(busyCycles), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .rdData(rdData), .readyOut(readyOut)
  );

  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: a read strobe seen at a rising edge has its result one edge later
  always @(posedge clk) rdSeen <= rstN && rdStrobe;

  initial begin
    forever begin
      @(negedge clk);
      if (rdSeen) begin
        if (expQ.size() == 0) begin
          chk("scoreboard-empty", rdData, 8'hxx);
        end else begin
          chk(tagQ.pop_front(), rdData, expQ.pop_front());
        end
      end
    end
  end

  // driver
  task automatic readExp(input logic [7:0] addr, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rdStrobe = 1'b1;
    rdAddr = addr;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic startOp(input logic erase, input logic [7:0] addr, input logic [7:0] data,
                         input logic [7:0] mask, input int n);
    @(negedge clk);
    opStart = 1'b1;
    opErase = erase;
    progAddr = addr;
    progData = data;
    eraseMask = mask;
    busyCycles = 16'(n);
    @(negedge clk);
    opStart = 1'b0;
  endtask

  task automatic waitReady();
    while (!readyOut) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", {7'b0, readyOut}, 8'h01);
    chk("R1 rdData after reset", rdData, 8'h00);
    readExp(8'h12, 8'hFF, "R1 erased array after reset");
    readExp(8'hE7, 8'hFF, "R2 idle read");

    // R4/R6/R7 program with bit7 = 1
    startOp(1'b0, 8'h25, 8'hA5, 8'h00, 30);
    readExp(8'h25, 8'h40, "R4 R6 program first poll");
    readExp(8'h25, 8'h00, "R6 program second poll");
    readExp(8'h80, 8'h40, "R6 R7 R8 program poll elsewhere");
    waitReady();
    readExp(8'h25, 8'hA5, "R4 programmed byte");
    readExp(8'h26, 8'hFF, "R2 neighbour untouched");

    // R4 program with bit7 = 0
    startOp(1'b0, 8'h30, 8'h3C, 8'h00, 20);
    readExp(8'h30, 8'hC0, "R4 poll of zero bit7");
    waitReady();
    readExp(8'h30, 8'h3C, "R4 programmed byte 2");

    // R3 exact busy length
    startOp(1'b0, 8'h40, 8'h11, 8'h00, 5);
    repeat (4) @(negedge clk);
    chk("R3 busy in last cycle", {7'b0, readyOut}, 8'h00);
    @(negedge clk);
    chk("R3 ready after count", {7'b0, readyOut}, 8'h01);
    startOp(1'b0, 8'h41, 8'h5A, 8'h00, 0);
    chk("R3 zero count busy one cycle", {7'b0, readyOut}, 8'h00);
    @(negedge clk);
    chk("R3 zero count ready", {7'b0, readyOut}, 8'h01);

    // R9 start while busy ignored
    startOp(1'b0, 8'h50, 8'h77, 8'h00, 30);
    startOp(1'b1, 8'h00, 8'h00, 8'hFF, 2);
    waitReady();
    readExp(8'h50, 8'h77, "R9 running program kept");
    readExp(8'h25, 8'hA5, "R9 no erase performed");

    // R5/R7/R10 erase of sectors 1 and 5
    startOp(1'b1, 8'h00, 8'h00, 8'h22, 40);
    readExp(8'h25, 8'h44, "R5 R7 R10 erase read selected");
    readExp(8'h00, 8'h04, "R7 R10 erase read unselected");
    readExp(8'hA3, 8'h40, "R7 R10 erase read sector5");
    readExp(8'h60, 8'h00, "R6 R7 erase read sector3");
    waitReady();
    readExp(8'h25, 8'hFF, "R5 sector1 erased");
    readExp(8'h30, 8'hFF, "R5 sector1 erased 2");
    readExp(8'h40, 8'h11, "R5 sector2 kept");
    readExp(8'h41, 8'h5A, "R5 R3 sector2 kept 2");

    // R6 toggles cleared at a new start
    startOp(1'b0, 8'h30, 8'h80, 8'h00, 20);
    readExp(8'h30, 8'h40, "R6 toggle cleared on start");
    waitReady();
    readExp(8'h30, 8'h80, "R4 program after erase");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule